// File: doc/BRIEF.md
# Interrupt Redirection Delivery Engine

This block turns wire-level interrupt requests into message-signalled interrupts. It holds a table of redirection entries, one per input line. Each entry carries a vector, a delivery mode, a destination, a destination-mode bit, a trigger mode and a mask. The block also keeps one pending-request bit per entry and, for level-mode entries, a remote-pending flag. Input pins are sampled on every clock. When an entry is pending, unmasked and free to deliver, a small state machine builds a 32-bit address and a 32-bit data word from the entry. It offers them on a valid/ready port, one entry per accepted beat.

Level-mode requests are coalesced. Delivering a level entry sets its remote-pending flag, and while that flag is set the entry sends nothing more, whatever the pin does. The flag clears only when an end-of-interrupt arrives whose vector equals the entry's vector. If the pin is still high at that point, the entry is delivered again at once. Software fills the table through a write port, 32 bits at a time. Input pin 0 is steered to entry 2.

The state machine has two states. ST_IDLE waits for an eligible entry. The transition "pick" (ST_IDLE to ST_OFFER) happens when at least one entry is eligible: the lowest-numbered one is captured and its message is latched. ST_OFFER drives the message. The transition "hold" (ST_OFFER to ST_OFFER) is taken while ready is low. The transition "accept" (ST_OFFER to ST_IDLE) is taken on a beat with ready high, and commits the delivery.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset every entry reads as all-zero fields with the mask set, no entry is pending, no remote-pending flag is set, and msg_valid is low; raising any pins then yields no message.
- R2: Input pin 0 drives entry 2. Input pin 2 is not connected to any entry, so toggling it never produces a message. Every other pin n drives entry n.
- R3: For an edge-mode entry, a rising pin while the entry is masked is dropped: it never sets the pending bit, and unmasking the entry afterwards produces no message.
- R4: For an edge-mode entry that is unmasked, a rising pin produces exactly one message. The pending bit clears when that message is accepted, so no duplicate follows.
- R5: For a level-mode entry the pending bit follows the pin. A masked, high, level entry stays pending and is delivered once unmasked. If the pin fell before the unmask, nothing is delivered.
- R6: Delivering a level entry sets its remote-pending flag. While the flag is set, that entry produces no message, even if its pin toggles.
- R7: An end-of-interrupt with vector V clears the remote-pending flag of every entry whose vector equals V. If such an entry is unmasked and its pin is still high, it is delivered again. A non-matching vector changes nothing.
- R8: Writing an entry's low word with trigger mode edge forces its remote-pending flag to zero.
- R9: When several entries are eligible, they are delivered in ascending entry index order.
- R10: The message address is 0xFEE00000 OR (destination << 12) OR (destination-mode << 2). The message data is vector in bits 7:0, delivery mode in bits 10:8 and trigger mode (1 = level) in bit 15.
- R11: While msg_valid is high and msg_ready is low, msg_valid stays high and msg_addr/msg_data hold their values. Each accepted beat delivers one entry.
- R12: Low-word write layout: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11, trigger mode in bit 15, mask in bit 16. Bits 12 to 14 are ignored; in particular, bit 14 never sets the remote-pending flag. The high word carries the destination in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_ENTRIES | Interrupt request lines |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_hi | input | 1 | 1 selects the high word (destination), 0 the low word |
| wr_data | input | 32 | Write data |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| msg_valid | output | 1 | Message on offer |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
Almost every wrong internal state shows up at the message port within a few cycles of the stimulus that exposes it. A remote-pending flag that never clears looks like a missing message after a matching end-of-interrupt. A flag that is never set looks like a duplicate message while a level pin stays high. A pending bit that is not cleared on acceptance repeats an edge message on the very next beat. A bad priority pick swaps the order of two messages raised in the same cycle, and a stale message register changes the address or data during a stalled offer. The bench exercises each of these paths, then waits long enough to see any message that should or should not appear.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    // Stored fields of one redirection entry
    typedef struct packed {
        logic [15:0] dest;
        logic        masked;
        logic        level;
        logic        dest_logical;
        logic [2:0]  dmode;
        logic [7:0]  vector;
    } rte_t;

    localparam rte_t RTE_RESET = '{dest: 16'h0, masked: 1'b1, level: 1'b0,
                                   dest_logical: 1'b0, dmode: 3'b0, vector: 8'h0};

    // Pin steering: one pin is moved onto another entry
    localparam int REMAP_PIN   = 0;
    localparam int REMAP_ENTRY = 2;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } dlv_state_t;

    function automatic logic [31:0] form_addr(rte_t r, logic [31:0] base);
        return base | (32'(r.dest) << 12) | (32'(r.dest_logical) << 2);
    endfunction

    function automatic logic [31:0] form_data(rte_t r);
        return 32'(r.vector) | (32'(r.dmode) << 8) | (32'(r.level) << 15);
    endfunction

endpackage

// File: rtl/irq_entry_table.sv
module irq_entry_table
    import irq_redir_pkg::*;
#(
    parameter int N     = 24,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_hi,
    input  logic [31:0]      wr_data,
    input  logic             eoi_valid,
    input  logic [7:0]       eoi_vector,
    input  logic             commit_en,
    input  logic [IDX_W-1:0] commit_idx,
    output rte_t             ent_o [N],
    output logic [N-1:0]     remote_o
);

    for (genvar e = 0; e < N; e++) begin : g_ent
        rte_t ent_q;
        logic remote_q;
        logic wr_hit;
        logic commit_hit;
        logic eoi_hit;

        assign wr_hit     = wr_en && (wr_idx == IDX_W'(e));
        assign commit_hit = commit_en && (commit_idx == IDX_W'(e));
        assign eoi_hit    = eoi_valid && (eoi_vector == ent_q.vector);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= RTE_RESET;
            end else if (wr_hit) begin
                if (wr_hi) begin
                    ent_q.dest <= wr_data[31:16];
                end else begin
                    ent_q.vector       <= wr_data[7:0];
                    ent_q.dmode        <= wr_data[10:8];
                    ent_q.dest_logical <= wr_data[11];
                    ent_q.level        <= wr_data[15];
                    ent_q.masked       <= wr_data[16];
                end
            end
        end

        // Remote-pending: edge write clears, level delivery sets, EOI clears
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                remote_q <= 1'b0;
            end else if (wr_hit && !wr_hi && !wr_data[15]) begin
                remote_q <= 1'b0;
            end else if (commit_hit && ent_q.level) begin
                remote_q <= 1'b1;
            end else if (eoi_hit) begin
                remote_q <= 1'b0;
            end
        end

        assign ent_o[e]    = ent_q;
        assign remote_o[e] = remote_q;

        // R8: an edge-mode entry never carries a remote-pending flag
        a_r8_edge_no_remote: assert property (@(posedge clk) disable iff (!rst_n)
            !ent_q.level |-> !remote_q);

        // R7: a matching end-of-interrupt clears the flag
        a_r7_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_valid && remote_q && eoi_vector == ent_q.vector && !commit_hit)
            |=> !remote_q);
    end

endmodule

// File: rtl/irq_pend_tracker.sv
module irq_pend_tracker
    import irq_redir_pkg::*;
#(
    parameter int N     = 24,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pin_in,
    input  logic [N-1:0]     masked,
    input  logic [N-1:0]     level,
    input  logic             clear_en,
    input  logic [IDX_W-1:0] clear_idx,
    output logic [N-1:0]     pend_o
);

    logic [N-1:0] src;
    logic [N-1:0] src_q;
    logic [N-1:0] pend_q;

    for (genvar e = 0; e < N; e++) begin : g_src
        if (e == REMAP_ENTRY) begin : g_steer
            assign src[e] = pin_in[REMAP_PIN];
        end else if (e == REMAP_PIN) begin : g_none
            assign src[e] = 1'b0;
        end else begin : g_direct
            assign src[e] = pin_in[e];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    for (genvar e = 0; e < N; e++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[e] <= 1'b0;
            end else if (level[e]) begin
                pend_q[e] <= src[e];
            end else if (src[e] && !src_q[e] && !masked[e]) begin
                pend_q[e] <= 1'b1;
            end else if (clear_en && clear_idx == IDX_W'(e)) begin
                pend_q[e] <= 1'b0;
            end
        end

        // R3: masked edge entries never become pending
        a_r3_masked_edge_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_q[e] && masked[e] && !level[e]) |=> !pend_q[e]);
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_delivery_fsm.sv
module irq_delivery_fsm
    import irq_redir_pkg::*;
#(
    parameter int N     = 24,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     eligible,
    input  logic [31:0]      addr_tbl [N],
    input  logic [31:0]      data_tbl [N],
    input  logic             msg_ready,
    output logic             msg_valid,
    output logic [31:0]      msg_addr,
    output logic [31:0]      msg_data,
    output logic             commit_en,
    output logic [IDX_W-1:0] commit_idx
);

    dlv_state_t       state_q, state_d;
    logic [IDX_W-1:0] pick;
    logic [IDX_W-1:0] sel_q;
    logic [31:0]      addr_q, data_q;

    // Lowest eligible index wins
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eligible[i]) pick = IDX_W'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (|eligible) state_d = ST_OFFER;
            ST_OFFER: if (msg_ready) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && |eligible) begin
                sel_q  <= pick;
                addr_q <= addr_tbl[pick];
                data_q <= data_tbl[pick];
            end
        end
    end

    always_comb begin
        msg_valid  = (state_q == ST_OFFER);
        msg_addr   = addr_q;
        msg_data   = data_q;
        commit_en  = (state_q == ST_OFFER) && msg_ready;
        commit_idx = sel_q;
    end

    // R11: a stalled offer keeps its content
    a_r11_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
    import irq_redir_pkg::*;
#(
    parameter int          NUM_ENTRIES = 24,
    parameter logic [31:0] MSG_BASE    = 32'hFEE0_0000,
    localparam int         IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_ENTRIES-1:0] pin_in,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic                   wr_hi,
    input  logic [31:0]            wr_data,
    input  logic                   eoi_valid,
    input  logic [7:0]             eoi_vector,
    output logic                   msg_valid,
    input  logic                   msg_ready,
    output logic [31:0]            msg_addr,
    output logic [31:0]            msg_data
);

    rte_t                   ent [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] remote;
    logic [NUM_ENTRIES-1:0] pend;
    logic [NUM_ENTRIES-1:0] masked;
    logic [NUM_ENTRIES-1:0] level;
    logic [NUM_ENTRIES-1:0] eligible;
    logic [31:0]            addr_tbl [NUM_ENTRIES];
    logic [31:0]            data_tbl [NUM_ENTRIES];
    logic                   commit_en;
    logic [IDX_W-1:0]       commit_idx;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_view
        assign masked[e]   = ent[e].masked;
        assign level[e]    = ent[e].level;
        assign addr_tbl[e] = form_addr(ent[e], MSG_BASE);
        assign data_tbl[e] = form_data(ent[e]);
    end

    // Deliverable: pending, unmasked, and not waiting on an EOI
    assign eligible = pend & ~masked & (~level | ~remote);

    irq_entry_table #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_hi      (wr_hi),
        .wr_data    (wr_data),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector),
        .commit_en  (commit_en),
        .commit_idx (commit_idx),
        .ent_o      (ent),
        .remote_o   (remote)
    );

    irq_pend_tracker #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) i_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .masked    (masked),
        .level     (level),
        .clear_en  (commit_en),
        .clear_idx (commit_idx),
        .pend_o    (pend)
    );

    irq_delivery_fsm #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .eligible   (eligible),
        .addr_tbl   (addr_tbl),
        .data_tbl   (data_tbl),
        .msg_ready  (msg_ready),
        .msg_valid  (msg_valid),
        .msg_addr   (msg_addr),
        .msg_data   (msg_data),
        .commit_en  (commit_en),
        .commit_idx (commit_idx)
    );

endmodule

// File: tb/test_irq_redirect_engine.sv
module test_irq_redirect_engine;

    localparam int N     = 24;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     pin_in = '0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic             wr_hi = 1'b0;
    logic [31:0]      wr_data = '0;
    logic             eoi_valid = 1'b0;
    logic [7:0]       eoi_vector = '0;
    logic             msg_valid;
    logic             msg_ready = 1'b0;
    logic [31:0]      msg_addr, msg_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    irq_redirect_engine #(.NUM_ENTRIES(N)) i_irq_redirect_engine (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_hi(wr_hi), .wr_data(wr_data), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // Vector table: pin, vector, destination, mask, message expected
    localparam logic [30:0] VEC_TBL [6] = '{
        {5'd5,  8'h35, 16'h0001, 1'b0, 1'b1},
        {5'd0,  8'h42, 16'h0003, 1'b0, 1'b1},
        {5'd7,  8'h47, 16'h0000, 1'b1, 1'b0},
        {5'd23, 8'hF7, 16'hABCD, 1'b0, 1'b1},
        {5'd2,  8'h22, 16'h0002, 1'b0, 1'b0},
        {5'd1,  8'h11, 16'h00FF, 1'b0, 1'b1}
    };

    function automatic logic [31:0] lo_word(logic [7:0] vec, logic [2:0] dm, logic dl,
                                            logic lvl, logic msk);
        return {15'd0, msk, lvl, 3'b000, dl, dm, vec};
    endfunction

    function automatic logic [31:0] exp_addr(logic [15:0] dest, logic dl);
        return 32'hFEE0_0000 | ({16'd0, dest} << 12) | ({31'd0, dl} << 2);
    endfunction

    function automatic logic [31:0] exp_data(logic [7:0] vec, logic [2:0] dm, logic lvl);
        return {24'd0, vec} | ({29'd0, dm} << 8) | ({31'd0, lvl} << 15);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr_entry(input int idx, input bit hi, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic set_pin(input int p, input bit v);
        @(negedge clk);
        pin_in[p] = v;
    endtask

    task automatic expect_msg(input string req, input logic [31:0] ea,
                              input logic [31:0] ed, input int hold);
        bit seen = 1'b0;
        logic [31:0] a0, d0;
        for (int i = 0; i < 12 && !seen; i++) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(seen, {req, " message expected"}, {31'd0, seen}, 32'd1);
        if (seen) begin
            a0 = msg_addr; d0 = msg_data;
            if (hold > 0) begin
                repeat (hold) @(negedge clk);
                check(msg_valid && msg_addr == a0 && msg_data == d0,
                      "R11 stalled offer held", msg_addr, a0);
            end
            check(msg_addr == ea, {req, " addr"}, msg_addr, ea);
            check(msg_data == ed, {req, " data"}, msg_data, ed);
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
        end
    endtask

    task automatic expect_none(input string req, input int cyc);
        bit seen = 1'b0;
        repeat (cyc) begin
            @(negedge clk);
            if (msg_valid) seen = 1'b1;
        end
        check(!seen, {req, " no message"}, {31'd0, seen}, 32'd0);
        if (seen) begin
            msg_ready = 1'b1;
            @(negedge clk);
            msg_ready = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!msg_valid, "R1 valid low after reset", {31'd0, msg_valid}, 32'd0);
        pin_in = '1;
        expect_none("R1 all entries masked", 8);
        pin_in = '0;
        repeat (2) @(negedge clk);

        // Vector table walk: edge entries (R2 R3 R4 R10)
        foreach (VEC_TBL[k]) begin
            int          pin;
            int          ent;
            logic [7:0]  vec;
            logic [15:0] dst;
            pin = int'(VEC_TBL[k][30:26]);
            vec = VEC_TBL[k][25:18];
            dst = VEC_TBL[k][17:2];
            ent = (pin == 0) ? 2 : pin;
            wr_entry(ent, 1'b1, {dst, 16'h0});
            wr_entry(ent, 1'b0, lo_word(vec, 3'b000, 1'b0, 1'b0, VEC_TBL[k][1]));
            set_pin(pin, 1'b1);
            if (VEC_TBL[k][0]) begin
                expect_msg("R4 R10 R2 edge delivery", exp_addr(dst, 1'b0),
                           exp_data(vec, 3'b000, 1'b0), 0);
                expect_none("R4 single message per edge", 6);
            end else begin
                expect_none("R3 R2 dropped request", 8);
            end
            set_pin(pin, 1'b0);
            repeat (2) @(negedge clk);
        end

        // R3: unmasking after a dropped edge delivers nothing
        wr_entry(7, 1'b0, lo_word(8'h47, 3'b000, 1'b0, 1'b0, 1'b0));
        expect_none("R3 unmask after dropped edge", 8);

        // R9 + R11: two edges in one cycle, ascending order, stalled offer
        wr_entry(3, 1'b0, lo_word(8'h33, 3'b000, 1'b0, 1'b0, 1'b0));
        wr_entry(9, 1'b0, lo_word(8'h39, 3'b000, 1'b0, 1'b0, 1'b0));
        @(negedge clk);
        pin_in[3] = 1'b1; pin_in[9] = 1'b1;
        expect_msg("R9 first lowest", exp_addr(16'h0, 1'b0), exp_data(8'h33, 3'b000, 1'b0), 3);
        expect_msg("R9 second", exp_addr(16'h0, 1'b0), exp_data(8'h39, 3'b000, 1'b0), 0);
        pin_in[3] = 1'b0; pin_in[9] = 1'b0;

        // Level entry 10: R6 coalescing, R7 EOI handling
        wr_entry(10, 1'b1, {16'h0010, 16'h0});
        wr_entry(10, 1'b0, lo_word(8'h5A, 3'b001, 1'b1, 1'b1, 1'b0));
        set_pin(10, 1'b1);
        expect_msg("R6 R10 level delivery", exp_addr(16'h0010, 1'b1),
                   exp_data(8'h5A, 3'b001, 1'b1), 0);
        expect_none("R6 coalesced while high", 8);
        set_pin(10, 1'b0);
        set_pin(10, 1'b1);
        expect_none("R6 coalesced across toggle", 8);
        send_eoi(8'h5B);
        expect_none("R7 non-matching vector", 8);
        send_eoi(8'h5A);
        expect_msg("R7 redelivery after EOI", exp_addr(16'h0010, 1'b1),
                   exp_data(8'h5A, 3'b001, 1'b1), 0);
        set_pin(10, 1'b0);
        send_eoi(8'h5A);
        expect_none("R7 EOI with pin low", 8);
        set_pin(10, 1'b1);
        expect_msg("R6 flag cleared by EOI", exp_addr(16'h0010, 1'b1),
                   exp_data(8'h5A, 3'b001, 1'b1), 0);

        // R8 + R12: masked edge rewrite clears the flag; bits 12..14 ignored
        wr_entry(10, 1'b0, lo_word(8'h5A, 3'b001, 1'b1, 1'b0, 1'b1));
        wr_entry(10, 1'b0, lo_word(8'h5A, 3'b001, 1'b1, 1'b1, 1'b1));
        expect_none("R5 masked level held", 4);
        wr_entry(10, 1'b0, lo_word(8'h5A, 3'b001, 1'b1, 1'b1, 1'b0) | 32'h0000_7000);
        expect_msg("R8 R12 flag forced clear", exp_addr(16'h0010, 1'b1),
                   exp_data(8'h5A, 3'b001, 1'b1), 0);
        set_pin(10, 1'b0);
        send_eoi(8'h5A);

        // R5: masked level entry
        wr_entry(12, 1'b0, lo_word(8'h6C, 3'b000, 1'b0, 1'b1, 1'b1));
        set_pin(12, 1'b1);
        expect_none("R5 masked level pending", 6);
        wr_entry(12, 1'b0, lo_word(8'h6C, 3'b000, 1'b0, 1'b1, 1'b0));
        expect_msg("R5 delivered on unmask", exp_addr(16'h0, 1'b0),
                   exp_data(8'h6C, 3'b000, 1'b1), 0);
        send_eoi(8'h6C);
        expect_msg("R7 redelivery while high", exp_addr(16'h0, 1'b0),
                   exp_data(8'h6C, 3'b000, 1'b1), 0);
        wr_entry(12, 1'b0, lo_word(8'h6C, 3'b000, 1'b0, 1'b1, 1'b1));
        set_pin(12, 1'b0);
        send_eoi(8'h6C);
        wr_entry(12, 1'b0, lo_word(8'h6C, 3'b000, 1'b0, 1'b1, 1'b0));
        expect_none("R5 pin fell before unmask", 8);

        // R1: reset in mid-run restores masks
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(!msg_valid, "R1 valid low after second reset", {31'd0, msg_valid}, 32'd0);
        set_pin(10, 1'b1);
        expect_none("R1 entry masked after reset", 8);
        set_pin(10, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule